// File: doc/BRIEF.md
# Inter-Unit Semaphore Stall Controller

This block holds pipeline units of a command-driven graphics engine back until another unit has drained earlier work. Synchronization is requested through token state writes on a single write port. Each write names a source unit and a target unit and is one of two kinds. An arm write opens a semaphore for that pair. A stall write keeps the source unit's hold output high until the target unit has reported completion of the work issued before the arm. The usual use is an arm write followed by a stall write on the same pair, for example holding the rasterizer until the pixel engine has finished everything queued so far.

Each unit reports completion with a one-cycle done pulse. The block drives one hold output per unit. A separate stall command port, driven by the command stream, holds the front-end unit until its target unit next reports done. Every unit pair keeps its own semaphore state, so several pairs can be armed and waiting at the same time.

Top module: `semstall_top`

## Requirements
- R1: After reset every bit of `unitHold` and `badPair` is 0. Unit IDs 0 to NUM_UNITS-1 are valid and the front end is ID 0. `tokWrKind` is 0 for an arm write and 1 for a stall write.
- R2: If an arm write on pair (F,T) is followed by a done pulse of T, a later stall write on (F,T) leaves `unitHold[F]` low.
- R3: An arm write on (F,T) followed by a stall write on (F,T) before T's done pulse raises `unitHold[F]` in the cycle after the stall write. The hold stays high until the cycle after T's next done pulse.
- R4: A stall write on (F,T) with no armed semaphore for that pair holds F until the cycle after T's next done pulse.
- R5: A done pulse of T in the same cycle as a stall write on (F,T) satisfies the stall, and `unitHold[F]` stays low.
- R6: Pairs are independent. A unit's hold stays high while any of its pairs is waiting, and a done pulse of one target releases only the pairs aimed at that target.
- R7: A raised semaphore satisfies only one stall write. A second stall write on the same pair waits for a new done pulse.
- R8: A write whose source or target ID is NUM_UNITS or higher, or whose source equals its target, changes no state. `badPair` is high for exactly the cycle after that write.
- R9: A stall command to target T holds `unitHold[0]` until the cycle after T's next done pulse. A done pulse of T in the same cycle means no hold. A stall command aimed at ID 0 or at an out-of-range ID is ignored and flags `badPair`.
- R10: `unitHold` changes only in the cycle after a token write, a stall command or a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tokWrValid | input | 1 | Token write strobe |
| tokWrKind | input | 1 | 0 arm, 1 stall |
| tokFrom | input | 5 | Source (held) unit ID |
| tokTo | input | 5 | Target (awaited) unit ID |
| cmdStallValid | input | 1 | Stall command from the command stream |
| cmdStallTo | input | 5 | Unit the front end waits for |
| unitDone | input | NUM_UNITS | Per-unit completion pulses |
| unitHold | output | NUM_UNITS | Per-unit stall outputs |
| badPair | output | 1 | Invalid pair seen on the previous cycle |

## Verification
The checker enforces the following on every cycle. A hold rises only after a stall write or a stall command. A hold falls only after a done pulse. Hold outputs stay put when there is no input activity. `badPair` appears only after a write. Whether a raised semaphore is used up by exactly one stall, whether a done pulse in the same cycle satisfies a stall, and whether pairs stay separate can only be seen in the bench's sequences. The bench compares every cycle of a long random run against its own reference model and adds directed sequences for each corner case.

// File: rtl/semstall_pkg.sv
package semstall_pkg;
  localparam int ID_W = 5;

  typedef enum logic {
    KIND_ARM   = 1'b0,
    KIND_STALL = 1'b1
  } tokKind_e;

  // decoded, validated strobes from control to datapath
  typedef struct packed {
    logic            armEn;
    logic            stallEn;
    logic            cmdEn;
    logic [ID_W-1:0] fromId;
    logic [ID_W-1:0] toId;
    logic [ID_W-1:0] cmdTo;
  } semStrobe_t;
endpackage

// File: rtl/semstall_ctrl.sv
module semstall_ctrl
  import semstall_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int FE_ID     = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tokWrValid,
  input  logic            tokWrKind,
  input  logic [ID_W-1:0] tokFrom,
  input  logic [ID_W-1:0] tokTo,
  input  logic            cmdStallValid,
  input  logic [ID_W-1:0] cmdStallTo,
  output semStrobe_t      strobe,
  output logic            badPair
);
  logic tokOk, cmdOk, badNow;

  always_comb begin
    tokOk  = (int'(tokFrom) < NUM_UNITS) && (int'(tokTo) < NUM_UNITS) && (tokFrom != tokTo);
    cmdOk  = (int'(cmdStallTo) < NUM_UNITS) && (int'(cmdStallTo) != FE_ID);
    badNow = (tokWrValid && !tokOk) || (cmdStallValid && !cmdOk);

    strobe.armEn   = tokWrValid && tokOk && (tokWrKind == KIND_ARM);
    strobe.stallEn = tokWrValid && tokOk && (tokWrKind == KIND_STALL);
    strobe.cmdEn   = cmdStallValid && cmdOk;
    strobe.fromId  = tokFrom;
    strobe.toId    = tokTo;
    strobe.cmdTo   = cmdStallTo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) badPair <= 1'b0;
    else       badPair <= badNow;
  end
endmodule

// File: rtl/semstall_pairs.sv
module semstall_pairs
  import semstall_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int FE_ID     = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  semStrobe_t           strobe,
  input  logic [NUM_UNITS-1:0] unitDone,
  output logic [NUM_UNITS-1:0] unitHold
);
  localparam int PAIRS = NUM_UNITS * NUM_UNITS;

  logic [PAIRS-1:0]     waitMat;
  logic [NUM_UNITS-1:0] cmdWait;

  for (genvar f = 0; f < NUM_UNITS; f++) begin : g_from
    for (genvar t = 0; t < NUM_UNITS; t++) begin : g_to
      if (f != t) begin : g_pair
        logic armed, raised, waiting, hit, done;
        assign hit  = (int'(strobe.fromId) == f) && (int'(strobe.toId) == t);
        assign done = unitDone[t];

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            armed   <= 1'b0;
            raised  <= 1'b0;
            waiting <= 1'b0;
          end else if (strobe.armEn && hit) begin
            armed   <= 1'b1;
            raised  <= 1'b0;
            waiting <= waiting && !done;
          end else if (strobe.stallEn && hit) begin
            if (raised || done) begin
              armed   <= 1'b0;
              raised  <= 1'b0;
              waiting <= 1'b0;
            end else begin
              waiting <= 1'b1;
            end
          end else if (done) begin
            if (waiting) begin
              waiting <= 1'b0;
              armed   <= 1'b0;
            end else if (armed) begin
              armed  <= 1'b0;
              raised <= 1'b1;
            end
          end
        end
        assign waitMat[f*NUM_UNITS+t] = waiting;
      end else begin : g_diag
        assign waitMat[f*NUM_UNITS+t] = 1'b0;
      end
    end
  end

  for (genvar t = 0; t < NUM_UNITS; t++) begin : g_cmd
    if (t != FE_ID) begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cmdWait[t] <= 1'b0;
        else if (strobe.cmdEn && int'(strobe.cmdTo) == t)
          cmdWait[t] <= !unitDone[t];
        else if (unitDone[t])
          cmdWait[t] <= 1'b0;
      end
    end else begin : g_self
      assign cmdWait[t] = 1'b0;
    end
  end

  for (genvar f = 0; f < NUM_UNITS; f++) begin : g_hold
    if (f == FE_ID) begin : g_fe
      assign unitHold[f] = (|waitMat[f*NUM_UNITS +: NUM_UNITS]) || (|cmdWait);
    end else begin : g_unit
      assign unitHold[f] = |waitMat[f*NUM_UNITS +: NUM_UNITS];
    end
  end
endmodule

// File: rtl/semstall_top.sv
module semstall_top
  import semstall_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int FE_ID     = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tokWrValid,
  input  logic                 tokWrKind,
  input  logic [ID_W-1:0]      tokFrom,
  input  logic [ID_W-1:0]      tokTo,
  input  logic                 cmdStallValid,
  input  logic [ID_W-1:0]      cmdStallTo,
  input  logic [NUM_UNITS-1:0] unitDone,
  output logic [NUM_UNITS-1:0] unitHold,
  output logic                 badPair
);
  semStrobe_t strobe;

  semstall_ctrl #(.NUM_UNITS(NUM_UNITS), .FE_ID(FE_ID)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .tokWrValid(tokWrValid), .tokWrKind(tokWrKind),
    .tokFrom(tokFrom), .tokTo(tokTo),
    .cmdStallValid(cmdStallValid), .cmdStallTo(cmdStallTo),
    .strobe(strobe), .badPair(badPair)
  );

  semstall_pairs #(.NUM_UNITS(NUM_UNITS), .FE_ID(FE_ID)) u_pairs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .unitDone(unitDone), .unitHold(unitHold)
  );
endmodule

// File: rtl/semstall_chk.sv
module semstall_chk #(
  parameter int NUM_UNITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tokWrValid,
  input logic                 tokWrKind,
  input logic                 cmdStallValid,
  input logic [NUM_UNITS-1:0] unitDone,
  input logic [NUM_UNITS-1:0] unitHold,
  input logic                 badPair
);
  // R3
  hold_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(unitHold & ~$past(unitHold))) |-> $past((tokWrValid && tokWrKind) || cmdStallValid));

  // R4
  hold_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(~unitHold & $past(unitHold))) |-> $past(|unitDone));

  // R8
  bad_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    badPair |-> $past(tokWrValid || cmdStallValid));

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tokWrValid && !cmdStallValid && unitDone == '0) |=> $stable(unitHold));
endmodule

bind semstall_top semstall_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk(clk), .rstN(rstN), .tokWrValid(tokWrValid), .tokWrKind(tokWrKind),
  .cmdStallValid(cmdStallValid), .unitDone(unitDone),
  .unitHold(unitHold), .badPair(badPair)
);

// File: tb/semstall_top_bench.sv
module semstall_top_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tv = 1'b0, tk = 1'b0, cv = 1'b0;
  logic [4:0]   tf = '0, tt = '0, ct = '0;
  logic [N-1:0] dn = '0;
  logic [N-1:0] hold;
  logic         bad;

  int checks = 0, errors = 0, cyc = 0;
  bit mArm [N][N], mRai [N][N], mWait [N][N];
  bit mCmd [N];
  bit mBad;

  always #2 clk = ~clk;

  semstall_top #(.NUM_UNITS(N), .FE_ID(0)) u_semstall_top (
    .clk(clk), .rstN(rstN), .tokWrValid(tv), .tokWrKind(tk),
    .tokFrom(tf), .tokTo(tt), .cmdStallValid(cv), .cmdStallTo(ct),
    .unitDone(dn), .unitHold(hold), .badPair(bad)
  );

  function automatic logic [N-1:0] expHold();
    logic [N-1:0] h = '0;
    for (int f = 0; f < N; f++)
      for (int t = 0; t < N; t++)
        if (mWait[f][t]) h[f] = 1'b1;
    for (int t = 0; t < N; t++)
      if (mCmd[t]) h[0] = 1'b1;
    return h;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    bit tokOk, cmdOk, hit, d;
    tokOk = (tf < N) && (tt < N) && (tf != tt);
    cmdOk = (ct < N) && (ct != 0);
    mBad  = (tv && !tokOk) || (cv && !cmdOk);
    for (int f = 0; f < N; f++)
      for (int t = 0; t < N; t++) begin
        if (f == t) continue;
        hit = tv && tokOk && (int'(tf) == f) && (int'(tt) == t);
        d   = dn[t];
        if (hit && !tk) begin
          mArm[f][t] = 1; mRai[f][t] = 0; mWait[f][t] = mWait[f][t] && !d;
        end else if (hit && tk) begin
          if (mRai[f][t] || d) begin
            mArm[f][t] = 0; mRai[f][t] = 0; mWait[f][t] = 0;
          end else mWait[f][t] = 1;
        end else if (d) begin
          if (mWait[f][t]) begin mWait[f][t] = 0; mArm[f][t] = 0; end
          else if (mArm[f][t]) begin mArm[f][t] = 0; mRai[f][t] = 1; end
        end
      end
    for (int t = 1; t < N; t++) begin
      if (cv && cmdOk && int'(ct) == t) mCmd[t] = !dn[t];
      else if (dn[t]) mCmd[t] = 0;
    end
  endtask

  // one clock: inputs held across the edge, then model and compare
  task automatic step();
    logic [N-1:0] eh;
    @(posedge clk);
    #1;
    modelStep();
    eh = expHold();
    check(hold == eh, "R6 hold vs model", hold, eh);
    check(bad == mBad, "R8 badPair vs model", bad, mBad);
  endtask

  task automatic idle();
    tv = 0; cv = 0; dn = '0;
  endtask

  task automatic tok(input bit kind, input int f, input int t);
    idle(); tv = 1; tk = kind; tf = 5'(f); tt = 5'(t);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EA4));
    #5;
    check(hold == '0, "R1 hold after reset", hold, 0);
    check(bad == 1'b0, "R1 badPair after reset", bad, 0);
    @(negedge clk); rstN = 1;

    // R2: arm, done, then stall passes
    tok(0, 1, 2); step();
    idle(); dn[2] = 1; step();
    tok(1, 1, 2); step();
    check(hold[1] == 0, "R2 raised semaphore passes", hold[1], 0);

    // R3: arm then stall holds until done
    tok(0, 1, 2); step();
    tok(1, 1, 2); step();
    check(hold[1] == 1, "R3 hold after stall", hold[1], 1);
    idle(); step(); step();
    check(hold[1] == 1, "R3 hold persists", hold[1], 1);
    idle(); dn[2] = 1; step();
    check(hold[1] == 0, "R3 release after done", hold[1], 0);

    // R4: stall with no arm
    tok(1, 3, 4); step();
    check(hold[3] == 1, "R4 unarmed stall holds", hold[3], 1);
    idle(); dn[4] = 1; step();
    check(hold[3] == 0, "R4 unarmed release", hold[3], 0);

    // R5: done in same cycle as stall
    tok(1, 3, 4); dn[4] = 1; step();
    check(hold[3] == 0, "R5 same-cycle done", hold[3], 0);

    // R7: raised used once
    tok(0, 5, 6); step();
    idle(); dn[6] = 1; step();
    tok(1, 5, 6); step();
    check(hold[5] == 0, "R7 first stall passes", hold[5], 0);
    tok(1, 5, 6); step();
    check(hold[5] == 1, "R7 second stall waits", hold[5], 1);
    idle(); dn[6] = 1; step();

    // R6: two pairs on one source
    tok(1, 1, 2); step();
    tok(1, 1, 3); step();
    idle(); dn[2] = 1; step();
    check(hold[1] == 1, "R6 other pair still waits", hold[1], 1);
    idle(); dn[3] = 1; step();
    check(hold[1] == 0, "R6 all pairs released", hold[1], 0);

    // R8: invalid pairs
    tok(1, 9, 2); step();
    check(bad == 1, "R8 out of range flagged", bad, 1);
    check(hold == '0, "R8 out of range ignored", hold, 0);
    tok(1, 2, 2); step();
    check(bad == 1 && hold == '0, "R8 self pair ignored", {bad, hold}, 9'h100);
    idle(); step();
    check(bad == 0, "R8 flag lasts one cycle", bad, 0);

    // R9: front-end stall command
    idle(); cv = 1; ct = 5'd2; step();
    check(hold[0] == 1, "R9 command holds front end", hold[0], 1);
    idle(); dn[2] = 1; step();
    check(hold[0] == 0, "R9 command released", hold[0], 0);
    idle(); cv = 1; ct = 5'd0; step();
    check(bad == 1 && hold[0] == 0, "R9 command to front end ignored", {bad, hold[0]}, 2);
    idle(); cv = 1; ct = 5'd3; dn[3] = 1; step();
    check(hold[0] == 0, "R9 same-cycle done", hold[0], 0);

    // R10 and mixed traffic: random run against the model
    for (int i = 0; i < 3000; i++) begin
      idle();
      tv = ($urandom_range(0, 9) < 4);
      tk = 1'($urandom);
      tf = 5'($urandom_range(0, 9));
      tt = 5'($urandom_range(0, 9));
      cv = ($urandom_range(0, 9) == 0);
      ct = 5'($urandom_range(0, 9));
      dn = N'($urandom & $urandom & $urandom);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule